// File: doc/BRIEF.md
# Banked Group-1 Binary Point Register

This block holds the 3-bit binary point that an interrupt controller uses to divide an 8-bit group-1 priority into a preemption part and a subpriority part. It keeps one copy for secure accesses and one for non-secure accesses. Each copy has its own floor, and any write below that floor is raised to it. The register is read and written through a 64-bit data port. Only the three low bits carry state.

A common binary point mode can be turned on separately for each security state. In non-secure common mode, reads return the group-0 binary point plus one, capped at 7, and writes are dropped. In secure common mode, secure accesses pass through to the group-0 register instead. Reads return the group-0 value, and writes are handed out on a forwarding strobe. A redirect input marks an access that is being served by a virtual copy elsewhere. Such an access leaves this block untouched.

Top module: `bp_bank_reg`

## Requirements
- R1: Bits [63:3] of `rdData` always read as zero, whatever was written to them.
- R2: After reset, the secure copy holds GRP0_MIN (default 0) and the non-secure copy holds GRP0_MIN+1 capped at 7 (default 1).
- R3: A write with `secSel`=1, `cmnSec`=0 and `redirect`=0 updates the secure copy from `wrData[2:0]` at that clock edge, and the new value is visible on the following read.
- R4: A write with `secSel`=0, `cmnNs`=0 and `redirect`=0 updates only the non-secure copy. The secure copy keeps its value.
- R5: A write below the selected copy's floor stores the floor. With default parameters, writing 0 to the non-secure copy stores 1.
- R6: With `secSel`=0, `cmnNs`=1 and `redirect`=0, the read returns `grp0Bp`+1, saturated at 7.
- R7: With `secSel`=0, `cmnNs`=1 and `redirect`=0, writes leave the non-secure copy unchanged.
- R8: With `secSel`=1, `cmnSec`=1 and `redirect`=0, the read returns `grp0Bp`. A write raises `grp0WrEn` in the same cycle, with `grp0WrData` set to the written value clamped to GRP0_MIN. The secure copy is not changed.
- R9: With `redirect`=1, the read returns zero, no copy changes, and `grp0WrEn` stays low.
- R10: Read data is combinational from the current state and the control inputs. `grp0WrEn` is low whenever `wrEn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for this cycle's access |
| secSel | input | 1 | Security state of the access: 1 secure, 0 non-secure |
| wrData | input | 64 | Write data; only bits [2:0] are used |
| redirect | input | 1 | Access is served by the virtual copy elsewhere |
| cmnSec | input | 1 | Common binary point mode for secure state |
| cmnNs | input | 1 | Common binary point mode for non-secure state |
| grp0Bp | input | 3 | Current group-0 binary point |
| rdData | output | 64 | Read data |
| grp0WrEn | output | 1 | Forwarded write to the group-0 register |
| grp0WrData | output | 3 | Clamped value for the forwarded write |

## Verification
A write and a mode decision can fall in the same cycle. The mode bits, `secSel` and `redirect` are sampled together with `wrEn` to decide which copy, if any, takes the write, and whether the write is forwarded instead. The bench provokes this by toggling the common-mode bits and `redirect` randomly in the very cycles that carry writes. A reference model applies the requirements to the pre-edge inputs, and the bench then judges the outcome by reading both copies back after the mode bits are cleared. A read in the same cycle as a write is also checked to still show the old value.

// File: rtl/bp_bank_pkg.sv
package bp_bank_pkg;

  typedef enum logic [2:0] {
    RD_ZERO  = 3'd0,
    RD_SEC   = 3'd1,
    RD_NS    = 3'd2,
    RD_G0    = 3'd3,
    RD_G0INC = 3'd4
  } rdSrc_e;

  typedef struct packed {
    logic   wrSec;
    logic   wrNs;
    logic   fwdG0;
    rdSrc_e rdSrc;
  } bpStrobe_t;

  localparam int BANK_SEC = 0;
  localparam int BANK_NS  = 1;
  localparam int N_BANKS  = 2;

endpackage

// File: rtl/bp_bank_ctrl.sv
module bp_bank_ctrl
  import bp_bank_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrEn,
  input  logic      secSel,
  input  logic      redirect,
  input  logic      cmnSec,
  input  logic      cmnNs,
  output bpStrobe_t strb
);

  always_comb begin
    strb       = '0;
    strb.rdSrc = RD_ZERO;
    if (!redirect) begin
      if (secSel) begin
        if (cmnSec) begin
          strb.rdSrc = RD_G0;
          strb.fwdG0 = wrEn;
        end else begin
          strb.rdSrc = RD_SEC;
          strb.wrSec = wrEn;
        end
      end else begin
        if (cmnNs) begin
          strb.rdSrc = RD_G0INC;
        end else begin
          strb.rdSrc = RD_NS;
          strb.wrNs  = wrEn;
        end
      end
    end
  end

  // R9
  redirect_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    redirect |-> !(strb.wrSec || strb.wrNs || strb.fwdG0));

  // R7
  ns_cmn_nowrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!secSel && cmnNs) |-> !strb.wrNs);

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrSec, strb.wrNs, strb.fwdG0}));

endmodule

// File: rtl/bp_bank_dp.sv
module bp_bank_dp
  import bp_bank_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int BP_W     = 3,
  parameter int GRP0_MIN = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  bpStrobe_t         strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [BP_W-1:0]   grp0Bp,
  output logic [DATA_W-1:0] rdData,
  output logic              grp0WrEn,
  output logic [BP_W-1:0]   grp0WrData
);

  localparam int BP_MAX   = (1 << BP_W) - 1;
  localparam int NS_MIN_I = (GRP0_MIN + 1 > BP_MAX) ? BP_MAX : GRP0_MIN + 1;
  localparam logic [BP_W-1:0] SEC_MIN = BP_W'(GRP0_MIN);
  localparam logic [BP_W-1:0] NS_MIN  = BP_W'(NS_MIN_I);

  logic [BP_W-1:0] wrField;
  logic [BP_W-1:0] bankQ   [N_BANKS];
  logic [BP_W-1:0] bankNxt [N_BANKS];
  logic            bankWr  [N_BANKS];
  logic [BP_W:0]   g0Sum;
  logic [BP_W-1:0] g0Inc;
  logic [BP_W-1:0] rdField;

  assign wrField = wrData[BP_W-1:0];
  assign bankWr[BANK_SEC] = strb.wrSec;
  assign bankWr[BANK_NS]  = strb.wrNs;

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    localparam logic [BP_W-1:0] FLOOR = (b == BANK_SEC) ? SEC_MIN : NS_MIN;

    assign bankNxt[b] = (wrField < FLOOR) ? FLOOR : wrField;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        bankQ[b] <= FLOOR;
      end else if (bankWr[b]) begin
        bankQ[b] <= bankNxt[b];
      end
    end

    // R5
    floor_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      bankQ[b] >= FLOOR);

    // R4
    bank_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
      !bankWr[b] |=> $stable(bankQ[b]));
  end

  assign g0Sum = {1'b0, grp0Bp} + 1'b1;
  assign g0Inc = g0Sum[BP_W] ? BP_W'(BP_MAX) : g0Sum[BP_W-1:0];

  always_comb begin
    case (strb.rdSrc)
      RD_SEC:   rdField = bankQ[BANK_SEC];
      RD_NS:    rdField = bankQ[BANK_NS];
      RD_G0:    rdField = grp0Bp;
      RD_G0INC: rdField = g0Inc;
      default:  rdField = '0;
    endcase
  end

  assign rdData     = {{(DATA_W - BP_W){1'b0}}, rdField};
  assign grp0WrEn   = strb.fwdG0;
  assign grp0WrData = bankNxt[BANK_SEC];

  // R6
  g0inc_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdSrc == RD_G0INC && grp0Bp == BP_W'(BP_MAX)) |-> rdField == BP_W'(BP_MAX));

  // R1
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdData[DATA_W-1:BP_W] == '0);

endmodule

// File: rtl/bp_bank_reg.sv
module bp_bank_reg
  import bp_bank_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int BP_W     = 3,
  parameter int GRP0_MIN = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              secSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              redirect,
  input  logic              cmnSec,
  input  logic              cmnNs,
  input  logic [BP_W-1:0]   grp0Bp,
  output logic [DATA_W-1:0] rdData,
  output logic              grp0WrEn,
  output logic [BP_W-1:0]   grp0WrData
);

  bpStrobe_t strb;

  bp_bank_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .secSel   (secSel),
    .redirect (redirect),
    .cmnSec   (cmnSec),
    .cmnNs    (cmnNs),
    .strb     (strb)
  );

  bp_bank_dp #(
    .DATA_W   (DATA_W),
    .BP_W     (BP_W),
    .GRP0_MIN (GRP0_MIN)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrData     (wrData),
    .grp0Bp     (grp0Bp),
    .rdData     (rdData),
    .grp0WrEn   (grp0WrEn),
    .grp0WrData (grp0WrData)
  );

  // R10
  fwd_needs_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> !grp0WrEn);

  // R8
  fwd_sec_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    grp0WrEn |-> (secSel && cmnSec && !redirect));

endmodule

// File: tb/bp_bank_reg_tb.sv
module bp_bank_reg_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        secSel = 1'b0;
  logic [63:0] wrData = '0;
  logic        redirect = 1'b0;
  logic        cmnSec = 1'b0;
  logic        cmnNs = 1'b0;
  logic [2:0]  grp0Bp = '0;
  logic [63:0] rdData;
  logic        grp0WrEn;
  logic [2:0]  grp0WrData;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  logic [2:0] mSec;
  logic [2:0] mNs;

  always #2.5 clk = ~clk;

  bp_bank_reg u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .secSel     (secSel),
    .wrData     (wrData),
    .redirect   (redirect),
    .cmnSec     (cmnSec),
    .cmnNs      (cmnNs),
    .grp0Bp     (grp0Bp),
    .rdData     (rdData),
    .grp0WrEn   (grp0WrEn),
    .grp0WrData (grp0WrData)
  );

  function automatic logic [2:0] clampTo(logic [2:0] v, logic [2:0] fl);
    return (v < fl) ? fl : v;
  endfunction

  function automatic logic [63:0] expRead();
    if (redirect) return 64'd0;
    if (secSel) return cmnSec ? {61'd0, grp0Bp} : {61'd0, mSec};
    if (cmnNs) return (grp0Bp == 3'd7) ? 64'd7 : {61'd0, grp0Bp + 3'd1};
    return {61'd0, mNs};
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  // drive one access at the falling edge, check combinational outputs, then let the edge act
  task automatic access(string tag, logic w, logic s, logic [63:0] d,
                        logic rd, logic cs, logic cn, logic [2:0] g0);
    logic expFwd;
    @(negedge clk);
    wrEn = w; secSel = s; wrData = d; redirect = rd;
    cmnSec = cs; cmnNs = cn; grp0Bp = g0;
    #1;
    check({tag, " read"}, rdData, expRead());
    expFwd = w && s && cs && !rd;
    check({tag, " R8 fwd strobe"}, {63'd0, grp0WrEn}, {63'd0, expFwd});
    if (expFwd) check({tag, " R8 fwd data"}, {61'd0, grp0WrData}, {61'd0, clampTo(d[2:0], 3'd0)});
    @(posedge clk);
    if (w && !rd) begin
      if (s && !cs) mSec = clampTo(d[2:0], 3'd0);
      if (!s && !cn) mNs = clampTo(d[2:0], 3'd1);
    end
  endtask

  task automatic readBack(string tag, logic s);
    access(tag, 1'b0, s, 64'd0, 1'b0, 1'b0, 1'b0, 3'd0);
  endtask

  initial begin
    #(200000 * 5);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    void'($urandom(32'h5eed_b1b1));
    mSec = 3'd0;
    mNs  = 3'd1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R2 reset values
    readBack("R2 secure reset", 1'b1);
    readBack("R2 nonsecure reset", 1'b0);
    check("R2 model sec", {61'd0, mSec}, 64'd0);
    check("R2 model ns", {61'd0, mNs}, 64'd1);

    // R5 clamp, R4 banking
    access("R5 ns write 0", 1'b1, 1'b0, 64'd0, 1'b0, 1'b0, 1'b0, 3'd0);
    readBack("R5 ns clamped", 1'b0);
    access("R4 ns write 5", 1'b1, 1'b0, 64'd5, 1'b0, 1'b0, 1'b0, 3'd0);
    readBack("R4 ns value", 1'b0);
    readBack("R4 sec untouched", 1'b1);

    // R3 + R1: secure write with upper garbage; same-cycle read shows old value (R10)
    access("R3 sec write 6", 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFF6, 1'b0, 1'b0, 1'b0, 3'd0);
    readBack("R3 sec value", 1'b1);
    check("R1 upper bits", rdData & ~64'h7, 64'd0);

    // R6 saturation and increment
    access("R6 g0=7 sat", 1'b0, 1'b0, 64'd0, 1'b0, 1'b0, 1'b1, 3'd7);
    access("R6 g0=3", 1'b0, 1'b0, 64'd0, 1'b0, 1'b0, 1'b1, 3'd3);

    // R7 write in ns common mode ignored
    access("R7 ns cmn write", 1'b1, 1'b0, 64'd2, 1'b0, 1'b0, 1'b1, 3'd3);
    readBack("R7 ns kept 5", 1'b0);

    // R8 secure common mode forwards
    access("R8 sec cmn write", 1'b1, 1'b1, 64'd3, 1'b0, 1'b1, 1'b0, 3'd4);
    readBack("R8 sec kept 6", 1'b1);

    // R9 redirect
    access("R9 redirect sec wr", 1'b1, 1'b1, 64'd1, 1'b1, 1'b1, 1'b0, 3'd2);
    access("R9 redirect ns wr", 1'b1, 1'b0, 64'd7, 1'b1, 1'b0, 1'b0, 3'd2);
    readBack("R9 sec kept", 1'b1);
    readBack("R9 ns kept", 1'b0);

    // random mix: mode bits change in write cycles
    for (int i = 0; i < 600; i++) begin
      access("R3/R4/R6-R9 random", 1'($urandom), 1'($urandom), {$urandom, $urandom},
             ($urandom % 5) == 0, 1'($urandom), 1'($urandom), 3'($urandom));
      if ((i % 50) == 0) begin
        readBack("R4 random sec readback", 1'b1);
        readBack("R4 random ns readback", 1'b0);
      end
    end

    @(negedge clk);
    wrEn = 1'b0;
    report();
  end

endmodule